// File: doc/BRIEF.md
# SPI Slave Register Access Engine

This block lets an external SPI host read and write a bank of seven byte-wide registers (addresses 0 to 6). The host holds the chip-select low for one frame. A frame opens with a fixed identification byte, 8'h50. A command byte follows. Its high nibble selects read or write, and its low nibble gives the first register address. One or more data bytes come last. The block runs on its own system clock. It brings the three serial inputs into that domain through synchronizers and detects the serial clock edges there.

During a write, each data byte goes into the register the pointer selects, and the pointer then moves on. During a read, the block shifts out register contents for as long as the host keeps clocking. In both cases the pointer steps from 6 back to 0. When the identification byte or the instruction is wrong, the block drops the rest of the frame. The register contents are visible in parallel on `regs_flat`, the register at address k on bits [8k+7:8k].

Top module: `spi_ra_top`

## Requirements
- R1: SPI mode 0 with the most significant bit first. SDI is captured on a rising SCK edge, and SDO changes only after a falling SCK edge.
- R2: The first byte of a frame must equal 8'h50. With any other first byte, no register changes for the rest of that frame and SDO stays disabled.
- R3: In the second byte, bits [7:4] are the instruction and bits [3:0] the start address. 4'b1011 means read and 4'b1100 means write. With any other instruction, the rest of the frame is dropped.
- R4: In a write frame, each complete data byte is stored at the pointer, and the pointer then advances by one.
- R5: The pointer steps from address 6 to address 0, for reads and for writes alike.
- R6: In a read frame, the byte at the start address is shifted out during the third byte, and the next byte during each later byte. The data on SDI is ignored in this phase.
- R7: A write to addresses 7 to 15 is discarded, and a read from them returns 8'h00. Above 6, the pointer counts upward modulo 16.
- R8: Raising CS ends the frame, clears the bit counter and discards a partly received byte. The next frame starts again from its identification byte.
- R9: Outside the data phase of an accepted read frame, `sdo_en` is 0 and `sdo` is 0.
- R10: After reset, all registers read 8'h00 and `sdo`/`sdo_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_sdi | input | 1 | Serial data from host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sdo | output | 1 | Serial data to host |
| spi_sdo_en | output | 1 | Output driver enable for SDO |
| regs_flat | output | 56 | Parallel view of the seven registers |

## Verification
The last byte of a burst write can land on register 6 or register 0. In that case the register-file write and the pointer wrap from 6 to 0 fall in the same system clock cycle. Likewise, in a read, loading the next byte into the transmit shifter and the pointer wrap fall in the same cycle. Both cases are provoked by bursts that start at address 5 and at address 14. They are judged by the register values seen on `regs_flat` and by the byte order the host receives on SDO.

// File: rtl/spi_ra_pkg.sv
package spi_ra_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned NUM_REGS = 7;
    localparam logic [7:0]  ID_CODE  = 8'h50;
    localparam logic [3:0]  OP_READ  = 4'b1011;
    localparam logic [3:0]  OP_WRITE = 4'b1100;

    // frame phase of the serial controller
    typedef enum logic [2:0] {
        PH_ID   = 3'd0,
        PH_CMD  = 3'd1,
        PH_WR   = 3'd2,
        PH_RD   = 3'd3,
        PH_DROP = 3'd4
    } phase_e;

    // command byte layout: instruction in the upper nibble
    typedef struct packed {
        logic [3:0] op;
        logic [3:0] addr;
    } cmd_t;

    // next pointer value: after the last register go to zero, else count up
    function automatic logic [ADDR_W-1:0] ptr_step(
        input logic [ADDR_W-1:0] cur,
        input logic [ADDR_W-1:0] last
    );
        return (cur == last) ? '0 : cur + 1'b1;
    endfunction

endpackage

// File: rtl/spi_ra_sync.sv
module spi_ra_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_raw,
    input  logic sdi_raw,
    input  logic cs_n_raw,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi_s,
    output logic cs_idle
);
    // bit 2 = cs_n, bit 1 = sck, bit 0 = sdi
    localparam logic [2:0] IDLE_VAL = 3'b100;

    logic [STAGES-1:0][2:0] pipe;
    logic                   sck_q;
    logic [2:0]             last_stage;

    assign last_stage = pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < int'(STAGES); s++) begin
                pipe[s] <= IDLE_VAL;
            end
            sck_q <= 1'b0;
        end else begin
            pipe[0] <= {cs_n_raw, sck_raw, sdi_raw};
            for (int s = 1; s < int'(STAGES); s++) begin
                pipe[s] <= pipe[s-1];
            end
            sck_q <= last_stage[1];
        end
    end

    assign sck_rise = last_stage[1] & ~sck_q;
    assign sck_fall = ~last_stage[1] & sck_q;
    assign sdi_s    = last_stage[0];
    assign cs_idle  = last_stage[2];

endmodule

// File: rtl/spi_ra_frame.sv
module spi_ra_frame
    import spi_ra_pkg::*;
#(
    parameter int unsigned    DATA_W = BYTE_W,
    parameter int unsigned    AW     = ADDR_W,
    parameter int unsigned    NREGS  = NUM_REGS,
    parameter logic [7:0]     ID_VAL = ID_CODE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdi_s,
    input  logic              cs_idle,
    input  logic [DATA_W-1:0] rd_data,
    output logic [AW-1:0]     rd_addr,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_en,
    output logic [AW-1:0]     ptr,
    output logic              ptr_adv,
    output phase_e            phase
);
    localparam int unsigned   CNT_W    = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [AW-1:0] LAST_REG = AW'(NREGS - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic              tx_vld;
    logic [DATA_W-1:0] rx_byte;
    logic              byte_done;
    logic              rd_load;
    cmd_t              cmd;

    assign rx_byte   = {rx_sh[DATA_W-2:0], sdi_s};
    assign byte_done = sck_rise && (bit_cnt == LAST_BIT);
    assign cmd       = cmd_t'(rx_byte[7:0]);
    assign rd_load   = sck_fall && (phase == PH_RD) && (bit_cnt == '0);

    // register file write request for a completed data byte
    assign wr_en   = byte_done && (phase == PH_WR) && (ptr <= LAST_REG);
    assign wr_addr = ptr;
    assign wr_data = rx_byte;
    assign rd_addr = ptr;
    assign ptr_adv = (byte_done && (phase == PH_WR)) || rd_load;

    always_ff @(posedge clk) begin
        if (rst || cs_idle) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            tx_vld  <= 1'b0;
            ptr     <= '0;
            phase   <= PH_ID;
        end else begin
            if (sck_rise) begin
                rx_sh   <= rx_byte;
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (byte_done) begin
                unique case (phase)
                    PH_ID: begin
                        phase <= (rx_byte == ID_VAL) ? PH_CMD : PH_DROP;
                    end
                    PH_CMD: begin
                        ptr <= cmd.addr;
                        if (cmd.op == OP_WRITE) begin
                            phase <= PH_WR;
                        end else if (cmd.op == OP_READ) begin
                            phase <= PH_RD;
                        end else begin
                            phase <= PH_DROP;
                        end
                    end
                    PH_WR:   ptr <= ptr_step(ptr, LAST_REG);
                    PH_RD:   phase <= PH_RD;
                    default: phase <= PH_DROP;
                endcase
            end
            if (sck_fall && (phase == PH_RD)) begin
                if (bit_cnt == '0) begin
                    tx_sh  <= rd_data;
                    tx_vld <= 1'b1;
                    ptr    <= ptr_step(ptr, LAST_REG);
                end else begin
                    tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    assign sdo_en = tx_vld;
    assign sdo    = tx_vld & tx_sh[DATA_W-1];

endmodule

// File: rtl/spi_ra_regfile.sv
module spi_ra_regfile #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned AW     = 4,
    parameter int unsigned NREGS  = 7
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    output logic [NREGS*DATA_W-1:0] regs_flat
);
    logic [DATA_W-1:0] mem [NREGS];

    for (genvar k = 0; k < NREGS; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[k] <= '0;
            end else if (wr_en && (wr_addr == AW'(k))) begin
                mem[k] <= wr_data;
            end
        end
        assign regs_flat[k*DATA_W +: DATA_W] = mem[k];
    end

    // unmapped addresses read as zero
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < int'(NREGS); k++) begin
            if (rd_addr == AW'(k)) begin
                rd_data = mem[k];
            end
        end
    end

endmodule

// File: rtl/spi_ra_top.sv
module spi_ra_top
    import spi_ra_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DATA_W      = BYTE_W,
    parameter int unsigned AW          = ADDR_W,
    parameter int unsigned NREGS       = NUM_REGS,
    parameter logic [7:0]  ID_VAL      = ID_CODE
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    spi_sck,
    input  logic                    spi_sdi,
    input  logic                    spi_cs_n,
    output logic                    spi_sdo,
    output logic                    spi_sdo_en,
    output logic [NREGS*DATA_W-1:0] regs_flat
);
    logic              sck_rise;
    logic              sck_fall;
    logic              sdi_s;
    logic              cs_idle;
    logic [AW-1:0]     rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [AW-1:0]     ptr;
    logic              ptr_adv;
    phase_e            phase;

    spi_ra_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sck_raw  (spi_sck),
        .sdi_raw  (spi_sdi),
        .cs_n_raw (spi_cs_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sdi_s    (sdi_s),
        .cs_idle  (cs_idle)
    );

    spi_ra_frame #(
        .DATA_W (DATA_W),
        .AW     (AW),
        .NREGS  (NREGS),
        .ID_VAL (ID_VAL)
    ) u_frame (
        .clk      (clk),
        .rst      (rst),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sdi_s    (sdi_s),
        .cs_idle  (cs_idle),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sdo      (spi_sdo),
        .sdo_en   (spi_sdo_en),
        .ptr      (ptr),
        .ptr_adv  (ptr_adv),
        .phase    (phase)
    );

    spi_ra_regfile #(
        .DATA_W (DATA_W),
        .AW     (AW),
        .NREGS  (NREGS)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .regs_flat (regs_flat)
    );

endmodule

// File: rtl/spi_ra_checker.sv
module spi_ra_checker
    import spi_ra_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned AW     = 4,
    parameter int unsigned NREGS  = 7
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    cs_idle,
    input logic                    sdo,
    input logic                    sdo_en,
    input logic                    wr_en,
    input logic [AW-1:0]           wr_addr,
    input logic [AW-1:0]           ptr,
    input logic                    ptr_adv,
    input phase_e                  phase,
    input logic [NREGS*DATA_W-1:0] regs_flat
);
    localparam logic [AW-1:0] LAST_REG = AW'(NREGS - 1);

    assert_sdo_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !sdo_en |-> !sdo);

    assert_sdo_phase_R6: assert property (@(posedge clk) disable iff (rst)
        sdo_en |-> (phase == PH_RD));

    assert_cs_release_R8: assert property (@(posedge clk) disable iff (rst)
        cs_idle |=> (!sdo_en && (phase == PH_ID)));

    assert_wr_range_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr <= LAST_REG));

    assert_wr_phase_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (phase == PH_WR));

    assert_regs_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_flat));

    assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (ptr_adv && (ptr == LAST_REG)) |=> (ptr == '0));

endmodule

bind spi_ra_top spi_ra_checker #(
    .DATA_W (DATA_W),
    .AW     (AW),
    .NREGS  (NREGS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_idle   (cs_idle),
    .sdo       (spi_sdo),
    .sdo_en    (spi_sdo_en),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .ptr       (ptr),
    .ptr_adv   (ptr_adv),
    .phase     (phase),
    .regs_flat (regs_flat)
);

// File: tb/spi_ra_top_bench.sv
module spi_ra_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int NV         = 7;
    // each vector: {address[3:0], written byte, expected read-back}
    localparam logic [19:0] VEC [NV] = '{
        {4'd0,  8'hA5, 8'hA5},
        {4'd1,  8'h81, 8'h81},
        {4'd3,  8'h3C, 8'h3C},
        {4'd6,  8'hFF, 8'hFF},
        {4'd7,  8'h12, 8'h00},
        {4'd15, 8'h77, 8'h00},
        {4'd2,  8'h00, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        cs_n = 1'b1;
    logic        sdo;
    logic        sdo_en;
    logic [55:0] regs;
    int          checks = 0;
    int          errors = 0;
    logic        en_seen = 1'b0;
    logic [7:0]  rx;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_ra_top u_spi_ra_top (
        .clk        (clk),
        .rst        (rst),
        .spi_sck    (sck),
        .spi_sdi    (sdi),
        .spi_cs_n   (cs_n),
        .spi_sdo    (sdo),
        .spi_sdo_en (sdo_en),
        .regs_flat  (regs)
    );

    always @(negedge clk) if (sdo_en) en_seen <= 1'b1;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            sdi = tx[i];
            repeat (HALF) @(negedge clk);
            got[i] = sdo;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic cs_open();
        en_seen = 1'b0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_close();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2*HALF) @(negedge clk);
    endtask

    function automatic logic [7:0] reg_at(input int a);
        return regs[a*8 +: 8];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R8: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R10 reset state
        check("R10 regs", {8'h0, regs}, 64'h0);
        check("R10 sdo", {62'h0, sdo_en, sdo}, 64'h0);

        // table walk: write then read back each address (R1 R4 R6 R7)
        for (int v = 0; v < NV; v++) begin
            logic [3:0] a;
            a = VEC[v][19:16];
            cs_open();
            xfer(8'h50, d);
            xfer({4'b1100, a}, d);
            xfer(VEC[v][15:8], d);
            cs_close();
            cs_open();
            xfer(8'h50, d);
            check("R9 idle during id byte", {63'h0, en_seen}, 64'h0);
            xfer({4'b1011, a}, d);
            check("R9 sdo low in head", {56'h0, d}, 64'h0);
            xfer(8'hC3, rx);
            cs_close();
            check("R6 R7 R1 read-back", {56'h0, rx}, {56'h0, VEC[v][7:0]});
            if (a < 4'd7) check("R4 reg value", {56'h0, reg_at(int'(a))}, {56'h0, VEC[v][7:0]});
        end
        check("R7 no stray write", {8'h0, regs}, {8'h0, 8'hFF, 8'h00, 8'h00, 8'h3C, 8'h00, 8'h81, 8'hA5});

        // R2 bad identification, write attempt and read attempt
        cs_open();
        xfer(8'h51, d); xfer(8'hC1, d); xfer(8'h99, d);
        cs_close();
        check("R2 bad id no write", {56'h0, reg_at(1)}, 64'h81);
        cs_open();
        xfer(8'h40, d); xfer(8'hB1, d); xfer(8'h00, rx);
        cs_close();
        check("R2 bad id no sdo", {55'h0, en_seen, rx}, 64'h0);

        // R3 bad instruction
        cs_open();
        xfer(8'h50, d); xfer(8'hD1, d); xfer(8'h99, d);
        cs_close();
        check("R3 bad op no write", {56'h0, reg_at(1)}, 64'h81);
        cs_open();
        xfer(8'h50, d); xfer(8'h31, d); xfer(8'h00, rx);
        cs_close();
        check("R3 bad op no sdo", {55'h0, en_seen, rx}, 64'h0);

        // R5 burst write wrapping 5,6,0
        cs_open();
        xfer(8'h50, d); xfer(8'hC5, d);
        xfer(8'h11, d); xfer(8'h22, d); xfer(8'h33, d);
        cs_close();
        check("R5 burst write", {8'h0, regs}, {8'h0, 8'h22, 8'h11, 8'h00, 8'h3C, 8'h00, 8'h81, 8'h33});

        // R5 burst read wrapping 5,6,0,1
        cs_open();
        xfer(8'h50, d); xfer(8'hB5, d);
        xfer(8'hFF, rx); check("R5 read b0", {56'h0, rx}, 64'h11);
        xfer(8'hFF, rx); check("R5 read b1", {56'h0, rx}, 64'h22);
        xfer(8'hFF, rx); check("R5 read b2 wrap", {56'h0, rx}, 64'h33);
        xfer(8'hFF, rx); check("R5 read b3", {56'h0, rx}, 64'h81);
        cs_close();
        check("R9 released", {62'h0, sdo_en, sdo}, 64'h0);

        // R7 read from 14 counts 14,15,0
        cs_open();
        xfer(8'h50, d); xfer(8'hBE, d);
        xfer(8'h00, rx); check("R7 read 14", {56'h0, rx}, 64'h00);
        xfer(8'h00, rx); check("R7 read 15", {56'h0, rx}, 64'h00);
        xfer(8'h00, rx); check("R7 read wraps to 0", {56'h0, rx}, 64'h33);
        cs_close();

        // R8 abort mid data byte, then partial first byte
        cs_open();
        xfer(8'h50, d); xfer(8'hC2, d);
        for (int i = 0; i < 4; i++) begin
            sdi = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        cs_close();
        check("R8 partial byte dropped", {56'h0, reg_at(2)}, 64'h00);
        cs_open();
        for (int i = 0; i < 3; i++) begin
            sdi = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        cs_close();
        cs_open();
        xfer(8'h50, d); xfer(8'hC4, d); xfer(8'h5A, d);
        cs_close();
        check("R8 fresh frame after abort", {56'h0, reg_at(4)}, 64'h5A);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule